// File: doc/BRIEF.md
# Event Counter Bank

This block is a small bank of 32-bit event counters for performance monitoring. Each counter is pointed at one line of a vector of single-cycle event pulses by a number held in its type register. It increments on that event only while both the bank-wide run bit and the counter's own enable bit are set. When a counter wraps past its largest value it raises a sticky overflow flag. A registered interrupt line goes high whenever any overflow flag is set whose interrupt enable is also set.

Software reaches the bank through a flat word-addressed register port. Writes take effect at the clock edge and reads are combinational. The counter-enable mask and the interrupt-enable mask are each changed through a pair of registers: one sets bits and the other clears them. Both members of a pair read back the same mask. Type and value registers can be reached directly at their own addresses, or indirectly through a select register. The number of counters is a parameter from 1 to 31, and bits for counters that do not exist are dropped.

Top module: `evt_counter_bank`

Register addresses: 0x00 control, 0x01 enable-set, 0x02 enable-clear, 0x03 interrupt-enable-set, 0x04 interrupt-enable-clear, 0x05 overflow status (write ones to clear), 0x06 select, 0x07 indirect type, 0x08 indirect value, 0x20+n type of counter n, 0x40+n value of counter n. Other addresses read zero.

## Requirements
- R1: The control register reads back as follows. Bit 0 is the run bit, as last written. Bits 1 (reset event counters) and 2 (reset cycle counter) always read 0. Bit 6 (long mode) always reads 1. Bits 15:11 hold NUM_CNT. All other bits read 0. After reset the register reads 0x2040 when NUM_CNT is 4.
- R2: Writing ones to 0x01 sets those enable bits, and writing ones to 0x02 clears them. A read of either address returns the same current enable mask.
- R3: Bits at positions NUM_CNT and above are ignored on writes to any mask register and always read as 0.
- R4: The interrupt-enable pair at 0x03 and 0x04 follows the rules of R2 and R3.
- R5: A counter increments by one on a cycle where its selected event input is high only if the run bit and its own enable bit are both set. A counter that is enabled while the run bit is clear does not move.
- R6: Each type register holds an event number in bits 9:0, plus two stored exclude flags in bit 31 and bit 30. Its other bits read 0. An event number of NUM_EVT or more never counts.
- R7: A counter that increments from 0xFFFFFFFF becomes 0 and sets its bit in the overflow status register. That bit stays set until a one is written to it at 0x05.
- R8: Writing a counter's value register loads that value, so a counter can be preset just below the wrap point.
- R9: The select register (bits 4:0) routes 0x07 and 0x08 to the type and value of the selected counter. If the select value is NUM_CNT or more, those addresses read 0 and writes to them are ignored.
- R10: Writing control bit 1 zeroes every counter. This wins over an event that arrives in the same cycle.
- R11: The interrupt output is the OR over all counters of the overflow flag AND the interrupt enable, delayed by one register stage.
- R12: A write to a counter's value in the same cycle as one of its events loads the written value, and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_in | input | NUM_EVT | Event pulses, one line per event number |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The bench targets the masking corners. A design that kept unimplemented bits would read 0xFFFFFFFF back from the enable pair. A design that kept the two pair registers separately would return different masks from the set and clear addresses. It forces counts with the run bit clear and on a disabled counter, and points a counter at an event number beyond the event vector. Any leak in the gating shows up as a non-zero count.

A counter is preset just below the wrap point. The bench checks the exact cycle the flag appears and that the interrupt lags it by one stage, which a combinational interrupt would fail. It also clears the flag and watches the interrupt drop one cycle later. Same-cycle collisions are checked too: counter reset with an event, and a value write with an event. Either one, if ordered wrongly, leaves a count of one. An out-of-range select that corrupted a counter would be seen when the counters are read directly.

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16,
  parameter int AW      = 7,
  parameter int EVW     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);

  localparam int SW        = 5;
  localparam int EIW       = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int TYPE_BASE = 32;
  localparam int VAL_BASE  = 64;
  localparam logic [31:0] TYPE_MASK = 32'hC000_0000 | 32'((1 << EVW) - 1);

  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_ENSET = AW'(1);
  localparam logic [AW-1:0] A_ENCLR = AW'(2);
  localparam logic [AW-1:0] A_IESET = AW'(3);
  localparam logic [AW-1:0] A_IECLR = AW'(4);
  localparam logic [AW-1:0] A_OVF   = AW'(5);
  localparam logic [AW-1:0] A_SEL   = AW'(6);
  localparam logic [AW-1:0] A_ITYPE = AW'(7);
  localparam logic [AW-1:0] A_IVAL  = AW'(8);

  logic                       run_q;
  logic [NUM_CNT-1:0]         en_q, ie_q, ovf_q, ovf_set;
  logic [SW-1:0]              sel_q;
  logic [NUM_CNT-1:0][31:0]   cnt_q, typ_q;
  logic                       irq_q;

  wire wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  wire clr_cnt  = wr_ctrl && reg_wdata[1];
  wire [NUM_CNT-1:0] wmask = reg_wdata[NUM_CNT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      en_q  <= '0;
      ie_q  <= '0;
      ovf_q <= '0;
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= reg_wdata[0];
      if (reg_wr && reg_addr == A_ENSET) en_q <= en_q | wmask;
      else if (reg_wr && reg_addr == A_ENCLR) en_q <= en_q & ~wmask;
      if (reg_wr && reg_addr == A_IESET) ie_q <= ie_q | wmask;
      else if (reg_wr && reg_addr == A_IECLR) ie_q <= ie_q & ~wmask;
      if (reg_wr && reg_addr == A_SEL) sel_q <= reg_wdata[SW-1:0];
      ovf_q <= (ovf_q & ~((reg_wr && reg_addr == A_OVF) ? wmask : '0)) | ovf_set;
      irq_q <= |(ovf_q & ie_q);
    end
  end

  assign irq = irq_q;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam logic [AW-1:0] A_T = AW'(TYPE_BASE + g);
    localparam logic [AW-1:0] A_V = AW'(VAL_BASE + g);
    wire           pick  = (sel_q == SW'(g));
    wire           wr_t  = reg_wr && (reg_addr == A_T || (reg_addr == A_ITYPE && pick));
    wire           wr_v  = reg_wr && (reg_addr == A_V || (reg_addr == A_IVAL && pick));
    wire [EVW-1:0] num   = typ_q[g][EVW-1:0];
    wire           ev_ok = (num < EVW'(NUM_EVT));
    wire           hit   = run_q && en_q[g] && ev_ok && evt_in[num[EIW-1:0]];

    assign ovf_set[g] = hit && !clr_cnt && !wr_v && (&cnt_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        typ_q[g] <= '0;
        cnt_q[g] <= '0;
      end else begin
        if (wr_t) typ_q[g] <= reg_wdata & TYPE_MASK;
        if (clr_cnt)   cnt_q[g] <= '0;
        else if (wr_v) cnt_q[g] <= reg_wdata;
        else if (hit)  cnt_q[g] <= cnt_q[g] + 32'd1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata = {16'h0, 5'(NUM_CNT), 4'h0, 1'b1, 5'h0, run_q};
      A_ENSET, A_ENCLR: reg_rdata = 32'(en_q);
      A_IESET, A_IECLR: reg_rdata = 32'(ie_q);
      A_OVF:            reg_rdata = 32'(ovf_q);
      A_SEL:            reg_rdata = 32'(sel_q);
      default:          ;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == AW'(TYPE_BASE + i)) reg_rdata = typ_q[i];
      if (reg_addr == AW'(VAL_BASE + i))  reg_rdata = cnt_q[i];
      if (sel_q == SW'(i)) begin
        if (reg_addr == A_ITYPE) reg_rdata = typ_q[i];
        if (reg_addr == A_IVAL)  reg_rdata = cnt_q[i];
      end
    end
  end

  AST_ENSET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENSET) |=> ((en_q & $past(wmask)) == $past(wmask))); // R2
  AST_ENCLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENCLR) |=> ((en_q & $past(wmask)) == '0)); // R2
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_wr) |=> $stable(cnt_q)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R7
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (cnt_q == '0)); // R10
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_q & ie_q)) |=> irq); // R11
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ovf_q & ie_q)) |=> !irq); // R11

endmodule

// File: tb/sim_evt_counter_bank.sv
module sim_evt_counter_bank;
  localparam int NC = 4;
  localparam int NE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [6:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_counter_bank #(.NUM_CNT(NC), .NUM_EVT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [6:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset_state;
    rdchk("R1 reset ctrl", 7'h00, 32'h0000_2040);
    rdchk("R2 reset enable", 7'h01, 32'h0);
    rdchk("R7 reset ovf", 7'h05, 32'h0);
    chk("R11 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_ctrl;
    wr(7'h00, 32'hFFFF_FFFF);
    rdchk("R1 ctrl pulse bits read 0", 7'h00, 32'h0000_2041);
    wr(7'h00, 32'h0);
    rdchk("R1 ctrl run cleared", 7'h00, 32'h0000_2040);
  endtask

  task automatic t_masks;
    wr(7'h01, 32'hFFFF_FFFF);
    rdchk("R3 enset drops unimplemented", 7'h01, 32'hF);
    rdchk("R2 enclr mirrors", 7'h02, 32'hF);
    wr(7'h02, ~32'h3);
    rdchk("R2 enset after clear", 7'h01, 32'h3);
    rdchk("R2 enclr after clear", 7'h02, 32'h3);
    wr(7'h03, 32'hFFFF_FFFF);
    rdchk("R4 ieset drops unimplemented", 7'h03, 32'hF);
    wr(7'h04, 32'h0000_000F);
    rdchk("R4 ieclr mirrors", 7'h04, 32'h0);
  endtask

  task automatic t_counting;
    wr(7'h20, 32'd2);
    wr(7'h21, 32'h8000_0005);
    wr(7'h22, 32'd20);
    wr(7'h23, 32'hFFFF_FFFF);
    rdchk("R6 type exclude flag kept", 7'h21, 32'h8000_0005);
    rdchk("R6 type unused bits zero", 7'h23, 32'hC000_03FF);
    wr(7'h00, 32'h2);
    wr(7'h02, 32'hF);
    wr(7'h01, 32'h7);
    for (int k = 0; k < 3; k++) pulse(NE'(1) << 2);
    rdchk("R5 no count while halted", 7'h40, 32'h0);
    wr(7'h00, 32'h1);
    for (int k = 0; k < 3; k++) pulse(NE'(1) << 2);
    for (int k = 0; k < 2; k++) pulse(NE'(1) << 5);
    rdchk("R5 counter0 event 2", 7'h40, 32'd3);
    rdchk("R6 counter1 event 5", 7'h41, 32'd2);
    wr(7'h02, 32'h2);
    pulse('1);
    rdchk("R5 counter0 all events", 7'h40, 32'd4);
    rdchk("R5 disabled counter1 frozen", 7'h41, 32'd2);
    rdchk("R6 out of range event", 7'h42, 32'd0);
  endtask

  task automatic t_overflow;
    wr(7'h40, 32'hFFFF_FFFE);
    rdchk("R8 preset readback", 7'h40, 32'hFFFF_FFFE);
    pulse(NE'(1) << 2);
    rdchk("R7 no ovf at max", 7'h05, 32'h0);
    pulse(NE'(1) << 2);
    rdchk("R7 wrapped to zero", 7'h40, 32'h0);
    rdchk("R7 ovf flag set", 7'h05, 32'h1);
    chk("R11 irq masked", 32'(irq), 32'h0);
    wr(7'h03, 32'h1);
    chk("R11 irq one stage late", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R11 irq raised", 32'(irq), 32'h1);
    wr(7'h05, 32'h0);
    rdchk("R7 zero write keeps flag", 7'h05, 32'h1);
    wr(7'h05, 32'h1);
    rdchk("R7 flag cleared", 7'h05, 32'h0);
    chk("R11 irq still high", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R11 irq dropped", 32'(irq), 32'h0);
  endtask

  task automatic t_collisions;
    wr(7'h40, 32'd7);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'h00; reg_wdata = 32'h3; evt_in = NE'(1) << 2;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    rdchk("R10 reset beats event", 7'h40, 32'h0);
    rdchk("R10 counter1 zeroed", 7'h41, 32'h0);
    rdchk("R1 reset bit reads 0", 7'h00, 32'h0000_2041);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'h40; reg_wdata = 32'd100; evt_in = NE'(1) << 2;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    rdchk("R12 write beats event", 7'h40, 32'd100);
  endtask

  task automatic t_indirect;
    wr(7'h06, 32'h1);
    rdchk("R9 select readback", 7'h06, 32'h1);
    wr(7'h08, 32'h1234_5678);
    rdchk("R9 indirect value write", 7'h41, 32'h1234_5678);
    wr(7'h07, 32'h4000_000A);
    rdchk("R9 indirect type write", 7'h21, 32'h4000_000A);
    rdchk("R9 indirect value read", 7'h08, 32'h1234_5678);
    wr(7'h06, 32'h7);
    rdchk("R9 out of range reads 0", 7'h08, 32'h0);
    wr(7'h08, 32'h0000_DEAD);
    rdchk("R9 out of range write ignored c0", 7'h40, 32'd100);
    rdchk("R9 out of range write ignored c3", 7'h43, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ctrl();
    t_masks();
    t_counting();
    t_overflow();
    t_collisions();
    t_indirect();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule